// File: doc/BRIEF.md
# Shared Bit Counting Unit

This unit is a purely combinational counter for one 32-bit operand. It gives one of three results: the number of set bits, the length of the zero run at the least significant end, or the length of the zero run at the most significant end. All three use one datapath. That datapath is a chain of single-bit increment stages, and it walks an internal vector from its least significant bit upward.

The unit changes its behaviour in two places. A preparation stage decides which bits enter the vector. The operand can go in unchanged, inverted, or bit-reversed and inverted. A cascaded enable chain then decides how far the count may run. For the population count every stage counts. For the two zero-run counts, a stage counts only while every lower vector bit qualified, so the count stops at the first one bit of the operand. The enable chain replaces a priority encoder.

The count is 6 bits wide and covers 0 to 32. It is zero-extended onto a 32-bit result port, so it can go straight onto a register write-back path. The unit is meant to sit beside an ALU that selects the operation with a 2-bit code.

Top module: `bitcount_unit`

## Requirements
- R1: With `opsel_i` = 2'b00 (population count), `count_o` equals the number of one bits in `operand_i`.
- R2: With `opsel_i` = 2'b01 (trailing-zero count), `count_o` equals the number of consecutive zero bits from bit 0 upward, stopping at the lowest one bit.
- R3: With `opsel_i` = 2'b10 (leading-zero count), `count_o` equals the number of consecutive zero bits from bit 31 downward, stopping at the highest one bit.
- R4: An all-zero operand gives 32 for both zero-run counts, and an all-ones operand gives 32 for the population count.
- R5: With `opsel_i` = 2'b11 (reserved), `count_o` is 0 whatever the operand.
- R6: Bits 31 down to 6 of `count_o` are always zero, and bits 5 down to 0 never exceed 32.
- R7: The unit holds no state. `count_o` follows a change of `operand_i` or `opsel_i` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value whose bits are counted |
| opsel_i | input | 2 | Operation: 00 population, 01 trailing zeros, 10 leading zeros, 11 reserved |
| count_o | output | 32 | Zero-extended count, 0 to 32 |

## Verification
The unit has no registers, so any fault in the reversal, the inversion, the enable cascade or an increment stage appears on `count_o` in the same evaluation as the input that triggers it. A broken enable link shows up as a zero-run count that runs past the first one bit or stops short of it. The fault becomes visible as soon as an operand places its boundary at that stage, so the bench sweeps single-bit and run-length patterns across every position. A reversal fault only distinguishes the leading count from the trailing count on asymmetric operands, so the vectors include operands whose two zero runs differ in length.

// File: rtl/bitcnt_pkg.sv
// Package: shared types for the bit counting unit.
// Assumes: the operation select is a 2-bit code decoded in one place.
package bitcnt_pkg;

    typedef enum logic [1:0] {
        CNT_POP  = 2'b00,
        CNT_TZ   = 2'b01,
        CNT_LZ   = 2'b10,
        CNT_RSVD = 2'b11
    } cnt_op_e;

endpackage

// File: rtl/bitcnt_prep.sv
// Module: bitcnt_prep
// Builds the vector that the increment chain counts and the controls for
// the enable chain. Zero-run counts invert the operand so that zero bits
// become counted ones; the leading count also reverses it so that the
// leading run sits at the least significant end.
// Assumes: purely combinational, W >= 2.
module bitcnt_prep
    import bitcnt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] operand_i,
    input  cnt_op_e      op_i,
    output logic [W-1:0] vec_o,
    output logic         run_mode_o,
    output logic         chain_go_o
);

    logic [W-1:0] reversed;

    // Bit reversal is pure wiring, one assignment per position.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign reversed[i] = operand_i[W-1-i];
    end

    // Select the vector source and the enable-chain mode per operation.
    always_comb begin
        vec_o      = operand_i;
        run_mode_o = 1'b0;
        chain_go_o = 1'b1;
        unique case (op_i)
            CNT_POP: begin
                vec_o      = operand_i;
                run_mode_o = 1'b0;
            end
            CNT_TZ: begin
                vec_o      = ~operand_i;
                run_mode_o = 1'b1;
            end
            CNT_LZ: begin
                vec_o      = ~reversed;
                run_mode_o = 1'b1;
            end
            CNT_RSVD: begin
                vec_o      = operand_i;
                run_mode_o = 1'b0;
                chain_go_o = 1'b0;
            end
            default: begin
                chain_go_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bitcnt_enable_chain.sv
// Module: bitcnt_enable_chain
// Cascaded stage enables. Stage 0 follows go_i. Each higher stage is
// enabled when the stage below was enabled and, in run mode, the vector
// bit below qualified (was one).
// Assumes: purely combinational; depth grows linearly with W.
module bitcnt_enable_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec_i,
    input  logic         run_mode_i,
    input  logic         go_i,
    output logic [W-1:0] en_o
);

    assign en_o[0] = go_i;

    // Each link passes the enable upward only past a qualifying bit.
    for (genvar i = 1; i < W; i++) begin : g_link
        assign en_o[i] = en_o[i-1] & (vec_i[i-1] | ~run_mode_i);
    end

endmodule

// File: rtl/bitcnt_incr_chain.sv
// Module: bitcnt_incr_chain
// A chain of W single-bit increment stages. Stage i adds one to the
// running total when it is enabled and its vector bit is set.
// Assumes: CW is wide enough to hold W.
module bitcnt_incr_chain #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    input  logic [W-1:0]  en_i,
    output logic [CW-1:0] count_o
);

    logic [CW-1:0] partial [W+1];

    assign partial[0] = '0;

    // One incrementer per bit position, fed by the stage below.
    for (genvar i = 0; i < W; i++) begin : g_stage
        assign partial[i+1] = partial[i] + {{(CW-1){1'b0}}, vec_i[i] & en_i[i]};
    end

    assign count_o = partial[W];

endmodule

// File: rtl/bitcount_unit.sv
// Module: bitcount_unit (top)
// Population, trailing-zero and leading-zero count on one shared chain of
// single-bit incrementers, with a zero-extended result.
// Assumes: combinational use inside a single-cycle execute stage; OUT_W > CW.
module bitcount_unit
    import bitcnt_pkg::*;
#(
    parameter int W     = 32,
    parameter int OUT_W = 32
) (
    input  logic [W-1:0]     operand_i,
    input  logic [1:0]       opsel_i,
    output logic [OUT_W-1:0] count_o
);

    localparam int CW = $clog2(W + 1);

    cnt_op_e       op;
    logic [W-1:0]  vec;
    logic [W-1:0]  en;
    logic          run_mode;
    logic          chain_go;
    logic [CW-1:0] cnt;

    assign op = cnt_op_e'(opsel_i);

    bitcnt_prep #(.W(W)) u_prep (
        .operand_i  (operand_i),
        .op_i       (op),
        .vec_o      (vec),
        .run_mode_o (run_mode),
        .chain_go_o (chain_go)
    );

    bitcnt_enable_chain #(.W(W)) u_en (
        .vec_i      (vec),
        .run_mode_i (run_mode),
        .go_i       (chain_go),
        .en_o       (en)
    );

    bitcnt_incr_chain #(.W(W), .CW(CW)) u_inc (
        .vec_i   (vec),
        .en_i    (en),
        .count_o (cnt)
    );

    assign count_o = {{(OUT_W-CW){1'b0}}, cnt};

endmodule

// File: rtl/bitcount_unit_chk.sv
// Module: bitcount_unit_chk
// Relates the result port to the operand and select ports with immediate
// assertions, since the unit has no clock. Attached to bitcount_unit by bind.
module bitcount_unit_chk #(
    parameter int W     = 32,
    parameter int OUT_W = 32
) (
    input logic [W-1:0]     operand_i,
    input logic [1:0]       opsel_i,
    input logic [OUT_W-1:0] count_o
);

    localparam int CW = $clog2(W + 1);

    int           n;
    logic [W-1:0] below;
    logic [W-1:0] above;

    // Evaluate every property against the current port values.
    always_comb begin
        n     = int'(count_o[CW-1:0]);
        below = '0;
        above = '0;
        for (int i = 0; i < W; i++) begin
            if (i < n) begin
                below[i]       = 1'b1;
                above[W-1-i]   = 1'b1;
            end
        end
        if (!$isunknown({operand_i, opsel_i})) begin
            p_upper_zero_r6: assert (count_o[OUT_W-1:CW] == '0);
            p_range_r6: assert (n <= W);
            if (opsel_i == 2'b11) begin
                p_rsvd_zero_r5: assert (count_o == '0);
            end
            if (opsel_i == 2'b00) begin
                p_pop_match_r1: assert (n == $countones(operand_i));
            end
            if (opsel_i == 2'b01 && operand_i != '0) begin
                p_tz_run_r2: assert (n < W && operand_i[n % W] && (operand_i & below) == '0);
            end
            if (opsel_i == 2'b10 && operand_i != '0) begin
                p_lz_run_r3: assert (n < W && operand_i[W-1-(n % W)] && (operand_i & above) == '0);
            end
            if (operand_i == '0 && (opsel_i == 2'b01 || opsel_i == 2'b10)) begin
                p_zero_full_r4: assert (n == W);
            end
        end
    end

endmodule

bind bitcount_unit bitcount_unit_chk #(.W(W), .OUT_W(OUT_W)) u_chk (
    .operand_i (operand_i),
    .opsel_i   (opsel_i),
    .count_o   (count_o)
);

// File: tb/test_bitcount_unit.sv
// Bench for bitcount_unit: vector table walk, then directed and swept checks.
module test_bitcount_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand;
    logic [1:0]  opsel;
    logic [31:0] result;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bitcount_unit i_bitcount_unit (
        .operand_i (operand),
        .opsel_i   (opsel),
        .count_o   (result)
    );

    // Table entry: {opsel[1:0], operand[31:0], expected[5:0]}.
    localparam int NV = 19;
    localparam logic [39:0] VEC [NV] = '{
        {2'b00, 32'h0000_0000, 6'd0},   // R1
        {2'b00, 32'hFFFF_FFFF, 6'd32},  // R4
        {2'b00, 32'h8000_0001, 6'd2},   // R1
        {2'b00, 32'h0F0F_0F0F, 6'd16},  // R1
        {2'b00, 32'hA5A5_A5A5, 6'd16},  // R1
        {2'b01, 32'h0000_0001, 6'd0},   // R2
        {2'b01, 32'h8000_0000, 6'd31},  // R2
        {2'b01, 32'h0000_0000, 6'd32},  // R4
        {2'b01, 32'h0000_0100, 6'd8},   // R2
        {2'b01, 32'hFFFF_0000, 6'd16},  // R2
        {2'b01, 32'h00F0_0000, 6'd20},  // R2
        {2'b10, 32'h0000_0001, 6'd31},  // R3
        {2'b10, 32'h8000_0000, 6'd0},   // R3
        {2'b10, 32'h0000_0000, 6'd32},  // R4
        {2'b10, 32'h0000_FFFF, 6'd16},  // R3
        {2'b10, 32'h0080_0000, 6'd8},   // R3
        {2'b10, 32'h00F0_0000, 6'd8},   // R3
        {2'b11, 32'hFFFF_FFFF, 6'd0},   // R5
        {2'b11, 32'h0000_0000, 6'd0}    // R5
    };

    function automatic int ref_count(input logic [31:0] v, input logic [1:0] s);
        int c = 0;
        case (s)
            2'b00: for (int i = 0; i < 32; i++) c += int'(v[i]);
            2'b01: begin
                c = 32;
                for (int i = 31; i >= 0; i--) if (v[i]) c = i;
            end
            2'b10: begin
                c = 32;
                for (int i = 0; i < 32; i++) if (v[i]) c = 31 - i;
            end
            default: c = 0;
        endcase
        return c;
    endfunction

    function automatic string tag_of(input logic [1:0] s);
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%b operand=%h got %0d expected %0d",
                     tag, opsel, operand, result, exp);
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        opsel   = s;
        operand = v;
        #1;
    endtask

    initial begin
        operand = '0;
        opsel   = 2'b00;
        repeat (2) @(negedge clk);
        #1;
        check("R1", 32'd0);  // reset state: zero operand counts zero
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][39:38], VEC[k][37:6]);
            check(VEC[k][39:38] == 2'b11 ? "R5" :
                  (VEC[k][37:6] == 32'h0 || VEC[k][37:6] == 32'hFFFF_FFFF) ? "R4" :
                  tag_of(VEC[k][39:38]), {26'd0, VEC[k][5:0]});
        end

        // Walking one bit: both zero runs at every boundary position.
        for (int p = 0; p < 32; p++) begin
            apply(2'b01, 32'h1 << p);
            check("R2", 32'(p));
            apply(2'b10, 32'h1 << p);
            check("R3", 32'(31 - p));
        end

        // R7: no clock edge between an input change and the sample.
        @(negedge clk);
        opsel = 2'b00; operand = 32'h0000_00FF; #1;
        check("R7", 32'd8);
        operand = 32'h0000_0F00; #1;
        check("R7", 32'd4);
        opsel = 2'b10; #1;
        check("R7", 32'd20);

        // Pseudo-random sweep against the bench model, all four codes.
        begin
            logic [31:0] lfsr = 32'hACE1_1234;
            for (int k = 0; k < 300; k++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                for (int s = 0; s < 4; s++) begin
                    apply(2'(s), lfsr >> (k % 24));
                    check(tag_of(2'(s)), 32'(ref_count(lfsr >> (k % 24), 2'(s))));
                    n_run++;
                    if (result[31:6] != 26'd0 || result > 32'd32) begin
                        n_fail++;
                        $display("FAIL R6: got %h expected upper bits zero and <= 32", result);
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule